// File: doc/BRIEF.md
# SPI Controller Data Word Port

This block is the data-register side of an SPI controller. A 32-bit register bus writes bytes into a transmit FIFO and reads bytes out of a receive FIFO. The serial shifter drains the transmit FIFO and fills the receive FIFO one byte at a time. In byte mode, each register access moves one byte in the low eight bits of the word. In packed mode, each access moves four bytes at once. Packed mode works only while the unit-length code selects 8-bit units.

The block shows software how full each FIFO is, in units of one access. It also reports each FIFO's depth as a code, and it flags accesses that had to be discarded. A three-bit control write starts self-clearing flushes of either FIFO or of the whole port. Two request lines let a DMA engine service each FIFO in bursts of half its depth.

Top module: `spi_word_port`

## Requirements
- R1: In byte mode, an accepted data write puts `dat_wdata[7:0]` into the transmit FIFO. The serial side sees bytes in write order: `ser_tx_byte` shows the oldest byte while `ser_tx_avail` is high, and `ser_tx_take` removes it.
- R2: Packed mode is in effect when `merge_en` is 1 and `unit_len` is 7. In packed mode, an accepted write adds four bytes, and `dat_wdata[7:0]` leaves first, then bits [15:8], [23:16] and [31:24].
- R3: An accepted read updates `dat_rdata` on the clock edge that samples `dat_rd`. In byte mode it returns the oldest byte in bits [7:0] with the upper bits zero. In packed mode it removes four bytes, with the oldest in bits [7:0] and later bytes in higher lanes.
- R4: When `unit_len` is not 7, `merge_en` has no effect and every access moves a single byte.
- R5: Let N be the number of bytes per access (4 in packed mode, 1 otherwise). `tx_full` is high while the transmit FIFO has fewer than N free entries. `rx_empty` is high while the receive FIFO holds fewer than N bytes.
- R6: A write while `tx_full` is high leaves the transmit FIFO unchanged and sets the sticky `tx_ovf_err`. A read while `rx_empty` is high leaves the receive FIFO unchanged, returns zero and sets the sticky `rx_udf_err`.
- R7: A `ctl_wr` with `ctl_wdata` bit 2 flushes the transmit FIFO, bit 1 flushes the receive FIFO, and bit 0 flushes both and also clears both error flags and `dat_rdata`. The requested bits show on `rst_pend` for one cycle, then read back zero, and the FIFO levels are zero on the next cycle.
- R8: `tx_depth_code` and `rx_depth_code` hold n, where the FIFO depth is 2^(n+1) entries.
- R9: `tx_dma_req` is high exactly while `tx_dma_en` is high and the transmit FIFO has at least half its depth free.
- R10: `rx_dma_req` is high exactly while `rx_dma_en` is high and the receive FIFO holds at least half its depth.
- R11: A byte offered on `ser_rx_put` while the receive FIFO is full is discarded.
- R12: After reset, both levels are zero, `rx_empty` is high, `tx_full` is low, and the error flags, `dat_rdata`, `rst_pend` and both DMA requests are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_en | input | 1 | Request packed four-byte accesses |
| unit_len | input | 5 | Serial unit length minus one (7 = 8-bit units) |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 32 | Data register write value |
| dat_rd | input | 1 | Data register read strobe |
| dat_rdata | output | 32 | Value returned by the last read |
| ctl_wr | input | 1 | Flush control write strobe |
| ctl_wdata | input | 3 | Flush request: bit2 transmit, bit1 receive, bit0 whole port |
| rst_pend | output | 3 | Flush requests in progress, self-clearing |
| tx_full | output | 1 | Transmit FIFO cannot take one access |
| rx_empty | output | 1 | Receive FIFO cannot supply one access |
| tx_level | output | TX_AW+1 | Bytes held in the transmit FIFO |
| rx_level | output | RX_AW+1 | Bytes held in the receive FIFO |
| tx_ovf_err | output | 1 | Sticky: a write was discarded |
| rx_udf_err | output | 1 | Sticky: a read was discarded |
| tx_depth_code | output | 4 | Transmit depth code n, depth 2^(n+1) |
| rx_depth_code | output | 4 | Receive depth code n, depth 2^(n+1) |
| tx_dma_en | input | 1 | Enable transmit DMA requests |
| rx_dma_en | input | 1 | Enable receive DMA requests |
| tx_dma_req | output | 1 | Transmit FIFO has room for a burst |
| rx_dma_req | output | 1 | Receive FIFO holds a burst |
| ser_tx_avail | output | 1 | A byte is waiting for the shifter |
| ser_tx_byte | output | 8 | Oldest transmit byte |
| ser_tx_take | input | 1 | Shifter consumes the oldest transmit byte |
| ser_rx_put | input | 1 | Shifter delivers a received byte |
| ser_rx_byte | input | 8 | Received byte |

## Verification
The FIFO levels, `dat_rdata`, the error flags and `rst_pend` are registered, so each is due on the first clock edge after the stimulus that causes it. A flush needs two edges: one to latch the request and one to empty the FIFO. `tx_full`, `rx_empty`, the DMA requests and the serial-side outputs are decoded from the registered levels together with the current mode and enable inputs. They are therefore valid in the same cycle as those levels. The bench changes its inputs one time unit after a rising edge and applies a single stimulus per cycle. It advances its reference model by one edge, then compares every output one time unit after that edge, so each result is checked exactly in the cycle it is due.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
   localparam int BYTE_W    = 8;
   localparam int LANES     = 4;
   localparam int WORD_W    = BYTE_W * LANES;
   localparam int CNT_W     = 3;
   localparam logic [4:0] UNIT8_CODE = 5'd7;

   typedef struct packed {
      logic txf;
      logic rxf;
      logic all;
   } rst_req_t;
endpackage

// File: rtl/wp_byte_fifo.sv
module wp_byte_fifo #(
   parameter int AW         = 4,
   parameter int PUSH_LANES = 1,
   parameter int POP_LANES  = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic [2:0]                push_n,
   input  logic [8*PUSH_LANES-1:0]   push_data,
   input  logic [2:0]                pop_n,
   output logic [8*POP_LANES-1:0]    peek,
   output logic [AW:0]               level
);
   localparam int DEPTH = 1 << AW;
   localparam int LW    = AW + 1;

   generate
      if (AW < 2 || AW > 12) begin : g_bad_aw
         $error("wp_byte_fifo: AW must be 2..12");
      end
      if (PUSH_LANES < 1 || PUSH_LANES > 4 || POP_LANES < 1 || POP_LANES > 4) begin : g_bad_lanes
         $error("wp_byte_fifo: lane counts must be 1..4");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [LW-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         level_q <= '0;
      end else if (flush) begin
         wp_q    <= '0;
         rp_q    <= '0;
         level_q <= '0;
      end else begin
         wp_q    <= wp_q + AW'(push_n);
         rp_q    <= rp_q + AW'(pop_n);
         level_q <= level_q + LW'(push_n) - LW'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      if (!flush) begin
         for (int i = 0; i < PUSH_LANES; i++) begin
            if (3'(i) < push_n) mem[wp_q + AW'(i)] <= push_data[i*8 +: 8];
         end
      end
   end

   generate
      for (genvar g = 0; g < POP_LANES; g++) begin : g_peek
         assign peek[g*8 +: 8] = mem[rp_q + AW'(g)];
      end
   endgenerate

   assign level = level_q;
endmodule

// File: rtl/wp_reset_ctl.sv
module wp_reset_ctl
   import spi_wp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [2:0] ctl_bits,
   output logic [2:0] pend,
   output logic       flush_tx,
   output logic       flush_rx,
   output logic       clr_all
);
   rst_req_t pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= '0;
      else if (ctl_wr) pend_q <= rst_req_t'(ctl_bits);
      else             pend_q <= '0;
   end

   assign pend     = pend_q;
   assign flush_tx = pend_q.txf | pend_q.all;
   assign flush_rx = pend_q.rxf | pend_q.all;
   assign clr_all  = pend_q.all;
endmodule

// File: rtl/wp_dma_req.sv
module wp_dma_req #(
   parameter int AW    = 4,
   parameter bit IS_TX = 1'b1
) (
   input  logic        en,
   input  logic [AW:0] level,
   output logic        req
);
   localparam int          DEPTH = 1 << AW;
   localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF  = (AW+1)'(DEPTH / 2);

   generate
      if (IS_TX) begin : g_room
         assign req = en && ((FULLV - level) >= HALF);
      end else begin : g_fill
         assign req = en && (level >= HALF);
      end
   endgenerate
endmodule

// File: rtl/wp_bus_adapter.sv
module wp_bus_adapter
   import spi_wp_pkg::*;
#(
   parameter int TX_AW = 4,
   parameter int RX_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              merge_on,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              rd,
   input  logic [TX_AW:0]    tx_level,
   input  logic [RX_AW:0]    rx_level,
   input  logic [WORD_W-1:0] rx_peek,
   output logic [2:0]        tx_push_n,
   output logic [WORD_W-1:0] tx_push_data,
   output logic [2:0]        rx_pop_n,
   output logic              tx_full,
   output logic              rx_empty,
   output logic [WORD_W-1:0] rdata,
   output logic              tx_err,
   output logic              rx_err
);
   localparam logic [TX_AW:0] TX_FULLV = (TX_AW+1)'(1 << TX_AW);

   logic [2:0]        nb;
   logic [TX_AW:0]    tx_free;
   logic              wr_ok, rd_ok;
   logic [WORD_W-1:0] rd_word;
   logic [WORD_W-1:0] rdata_q;
   logic              tx_err_q, rx_err_q;

   assign nb       = merge_on ? 3'(LANES) : 3'd1;
   assign tx_free  = TX_FULLV - tx_level;
   assign tx_full  = tx_free < (TX_AW+1)'(nb);
   assign rx_empty = rx_level < (RX_AW+1)'(nb);
   assign wr_ok    = wr && !tx_full;
   assign rd_ok    = rd && !rx_empty;

   assign tx_push_n    = wr_ok ? nb : 3'd0;
   assign tx_push_data = wdata;
   assign rx_pop_n     = rd_ok ? nb : 3'd0;
   assign rd_word      = merge_on ? rx_peek : {{(WORD_W-BYTE_W){1'b0}}, rx_peek[BYTE_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         tx_err_q <= 1'b0;
         rx_err_q <= 1'b0;
      end else if (clr_all) begin
         rdata_q  <= '0;
         tx_err_q <= 1'b0;
         rx_err_q <= 1'b0;
      end else begin
         if (rd) rdata_q <= rd_ok ? rd_word : '0;
         if (wr && tx_full) tx_err_q <= 1'b1;
         if (rd && rx_empty) rx_err_q <= 1'b1;
      end
   end

   assign rdata  = rdata_q;
   assign tx_err = tx_err_q;
   assign rx_err = rx_err_q;
endmodule

// File: rtl/spi_word_port.sv
module spi_word_port
   import spi_wp_pkg::*;
#(
   parameter int TX_AW = 4,
   parameter int RX_AW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             merge_en,
   input  logic [4:0]       unit_len,
   input  logic             dat_wr,
   input  logic [31:0]      dat_wdata,
   input  logic             dat_rd,
   output logic [31:0]      dat_rdata,
   input  logic             ctl_wr,
   input  logic [2:0]       ctl_wdata,
   output logic [2:0]       rst_pend,
   output logic             tx_full,
   output logic             rx_empty,
   output logic [TX_AW:0]   tx_level,
   output logic [RX_AW:0]   rx_level,
   output logic             tx_ovf_err,
   output logic             rx_udf_err,
   output logic [3:0]       tx_depth_code,
   output logic [3:0]       rx_depth_code,
   input  logic             tx_dma_en,
   input  logic             rx_dma_en,
   output logic             tx_dma_req,
   output logic             rx_dma_req,
   output logic             ser_tx_avail,
   output logic [7:0]       ser_tx_byte,
   input  logic             ser_tx_take,
   input  logic             ser_rx_put,
   input  logic [7:0]       ser_rx_byte
);
   localparam int RX_DEPTH = 1 << RX_AW;
   localparam logic [RX_AW:0] RX_FULLV = (RX_AW+1)'(RX_DEPTH);

   generate
      if (TX_AW < 2 || TX_AW > 12 || RX_AW < 2 || RX_AW > 12) begin : g_bad_depth
         $error("spi_word_port: FIFO address widths must be 2..12");
      end
   endgenerate

   logic              flush_tx, flush_rx, clr_all;
   logic              merge_on;
   logic [2:0]        tx_push_n, rx_pop_n, tx_pop_n, rx_push_n;
   logic [WORD_W-1:0] tx_push_data, rx_peek;

   assign merge_on = merge_en && (unit_len == UNIT8_CODE);

   wp_reset_ctl u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_bits (ctl_wdata),
      .pend     (rst_pend),
      .flush_tx (flush_tx),
      .flush_rx (flush_rx),
      .clr_all  (clr_all)
   );

   wp_bus_adapter #(.TX_AW(TX_AW), .RX_AW(RX_AW)) u_bus (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_all      (clr_all),
      .merge_on     (merge_on),
      .wr           (dat_wr),
      .wdata        (dat_wdata),
      .rd           (dat_rd),
      .tx_level     (tx_level),
      .rx_level     (rx_level),
      .rx_peek      (rx_peek),
      .tx_push_n    (tx_push_n),
      .tx_push_data (tx_push_data),
      .rx_pop_n     (rx_pop_n),
      .tx_full      (tx_full),
      .rx_empty     (rx_empty),
      .rdata        (dat_rdata),
      .tx_err       (tx_ovf_err),
      .rx_err       (rx_udf_err)
   );

   assign ser_tx_avail = (tx_level != '0);
   assign tx_pop_n     = (ser_tx_take && ser_tx_avail) ? 3'd1 : 3'd0;
   assign rx_push_n    = (ser_rx_put && (rx_level < RX_FULLV)) ? 3'd1 : 3'd0;

   wp_byte_fifo #(.AW(TX_AW), .PUSH_LANES(LANES), .POP_LANES(1)) u_txf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_tx),
      .push_n    (tx_push_n),
      .push_data (tx_push_data),
      .pop_n     (tx_pop_n),
      .peek      (ser_tx_byte),
      .level     (tx_level)
   );

   wp_byte_fifo #(.AW(RX_AW), .PUSH_LANES(1), .POP_LANES(LANES)) u_rxf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_rx),
      .push_n    (rx_push_n),
      .push_data (ser_rx_byte),
      .pop_n     (rx_pop_n),
      .peek      (rx_peek),
      .level     (rx_level)
   );

   wp_dma_req #(.AW(TX_AW), .IS_TX(1'b1)) u_txdma (
      .en    (tx_dma_en),
      .level (tx_level),
      .req   (tx_dma_req)
   );

   wp_dma_req #(.AW(RX_AW), .IS_TX(1'b0)) u_rxdma (
      .en    (rx_dma_en),
      .level (rx_level),
      .req   (rx_dma_req)
   );

   assign tx_depth_code = 4'(TX_AW - 1);
   assign rx_depth_code = 4'(RX_AW - 1);
endmodule

// File: rtl/spi_word_port_chk.sv
module spi_word_port_chk #(
   parameter int TX_AW = 4,
   parameter int RX_AW = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           dat_wr,
   input logic           dat_rd,
   input logic [31:0]    dat_rdata,
   input logic           ctl_wr,
   input logic [2:0]     rst_pend,
   input logic           tx_full,
   input logic           rx_empty,
   input logic [TX_AW:0] tx_level,
   input logic [RX_AW:0] rx_level,
   input logic           tx_ovf_err,
   input logic           rx_udf_err,
   input logic           tx_dma_en,
   input logic           rx_dma_en,
   input logic           tx_dma_req,
   input logic           rx_dma_req,
   input logic           ser_rx_put
);
   localparam int TXD = 1 << TX_AW;
   localparam int RXD = 1 << RX_AW;

   // R5: levels never exceed depth
   a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_level) <= TXD) && (int'(rx_level) <= RXD));

   a_r6_wr_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && tx_full && !rst_pend[0]) |=> tx_ovf_err);

   a_r6_rd_drop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && rx_empty && !rst_pend[0]) |=> (rx_udf_err && dat_rdata == 32'd0));

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf_err && !rst_pend[0]) |=> tx_ovf_err);

   a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> (rst_pend == 3'b000));

   a_r7_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_pend[2] || rst_pend[0]) |=> (tx_level == '0));

   a_r7_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_pend[1] || rst_pend[0]) |=> (rx_level == '0));

   a_r9_tx_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req |-> (tx_dma_en && (TXD - int'(tx_level)) >= TXD / 2));

   a_r10_rx_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> (rx_dma_en && int'(rx_level) >= RXD / 2));

   a_r11_rx_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_rx_put && int'(rx_level) == RXD && !dat_rd && rst_pend == 3'b000)
      |=> (int'(rx_level) == RXD));
endmodule

bind spi_word_port spi_word_port_chk #(.TX_AW(TX_AW), .RX_AW(RX_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dat_wr     (dat_wr),
   .dat_rd     (dat_rd),
   .dat_rdata  (dat_rdata),
   .ctl_wr     (ctl_wr),
   .rst_pend   (rst_pend),
   .tx_full    (tx_full),
   .rx_empty   (rx_empty),
   .tx_level   (tx_level),
   .rx_level   (rx_level),
   .tx_ovf_err (tx_ovf_err),
   .rx_udf_err (rx_udf_err),
   .tx_dma_en  (tx_dma_en),
   .rx_dma_en  (rx_dma_en),
   .tx_dma_req (tx_dma_req),
   .rx_dma_req (rx_dma_req),
   .ser_rx_put (ser_rx_put)
);

// File: tb/sim_spi_word_port.sv
`timescale 1ns/1ps
module sim_spi_word_port;
   localparam int TX_AW = 4;
   localparam int RX_AW = 3;
   localparam int TXD = 1 << TX_AW;
   localparam int RXD = 1 << RX_AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         merge_en = 0;
   logic [4:0]   unit_len = 5'd7;
   logic         dat_wr = 0, dat_rd = 0, ctl_wr = 0;
   logic [31:0]  dat_wdata = 0;
   logic [2:0]   ctl_wdata = 0;
   logic         tx_dma_en = 0, rx_dma_en = 0;
   logic         ser_tx_take = 0, ser_rx_put = 0;
   logic [7:0]   ser_rx_byte = 0;
   logic [31:0]  dat_rdata;
   logic [2:0]   rst_pend;
   logic         tx_full, rx_empty, tx_ovf_err, rx_udf_err;
   logic [TX_AW:0] tx_level;
   logic [RX_AW:0] rx_level;
   logic [3:0]   tx_depth_code, rx_depth_code;
   logic         tx_dma_req, rx_dma_req, ser_tx_avail;
   logic [7:0]   ser_tx_byte;

   spi_word_port #(.TX_AW(TX_AW), .RX_AW(RX_AW)) u0 (.*);

   int n_chk = 0, n_err = 0;
   logic [7:0]  tq[$];
   logic [7:0]  rq[$];
   logic [2:0]  m_pend = 0;
   logic        m_txe = 0, m_rxe = 0;
   logic [31:0] m_rdata = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   function automatic int bytes_per_access(input logic m, input logic [4:0] ul);
      return (m && ul == 5'd7) ? 4 : 1;
   endfunction

   task automatic check_all();
      int nb;
      nb = bytes_per_access(merge_en, unit_len);
      chk("R2 tx_level", 32'(tx_level), 32'(tq.size()));
      chk("R3 rx_level", 32'(rx_level), 32'(rq.size()));
      chk("R3 rdata", dat_rdata, m_rdata);
      chk("R5 tx_full", 32'(tx_full), 32'((TXD - tq.size()) < nb));
      chk("R5 rx_empty", 32'(rx_empty), 32'(rq.size() < nb));
      chk("R6 tx_ovf_err", 32'(tx_ovf_err), 32'(m_txe));
      chk("R6 rx_udf_err", 32'(rx_udf_err), 32'(m_rxe));
      chk("R7 rst_pend", 32'(rst_pend), 32'(m_pend));
      chk("R9 tx_dma_req", 32'(tx_dma_req), 32'(tx_dma_en && (TXD - tq.size()) >= TXD/2));
      chk("R10 rx_dma_req", 32'(rx_dma_req), 32'(rx_dma_en && rq.size() >= RXD/2));
      chk("R1 tx_avail", 32'(ser_tx_avail), 32'(tq.size() != 0));
      if (tq.size() != 0) chk("R1 tx_byte", 32'(ser_tx_byte), 32'(tq[0]));
   endtask

   // advance the reference model by one edge, then compare
   task automatic step();
      int nb, tsz, rsz;
      logic ftx, frx, fall, efull, eempty;
      logic [31:0] w;
      nb = bytes_per_access(merge_en, unit_len);
      tsz = tq.size(); rsz = rq.size();
      ftx = m_pend[2] | m_pend[0];
      frx = m_pend[1] | m_pend[0];
      fall = m_pend[0];
      efull = (TXD - tsz) < nb;
      eempty = rsz < nb;
      if (fall) begin
         m_txe = 0; m_rxe = 0; m_rdata = 0;
      end else begin
         if (dat_wr && efull) m_txe = 1;
         if (dat_rd) begin
            if (eempty) begin m_rxe = 1; m_rdata = 0; end
            else begin
               w = 0;
               for (int i = 0; i < nb; i++) w[i*8 +: 8] = rq[i];
               m_rdata = w;
            end
         end
      end
      if (ftx) tq.delete();
      else begin
         if (ser_tx_take && tsz > 0) void'(tq.pop_front());
         if (dat_wr && !efull)
            for (int i = 0; i < nb; i++) tq.push_back(dat_wdata[i*8 +: 8]);
      end
      if (frx) rq.delete();
      else begin
         if (dat_rd && !eempty)
            for (int i = 0; i < nb; i++) void'(rq.pop_front());
         if (ser_rx_put && rsz < RXD) rq.push_back(ser_rx_byte);
      end
      m_pend = ctl_wr ? ctl_wdata : 3'b000;
      @(posedge clk);
      #1;
      check_all();
   endtask

   task automatic idle();
      dat_wr = 0; dat_rd = 0; ctl_wr = 0; ser_tx_take = 0; ser_rx_put = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      report();
   end

   initial begin
      void'($urandom(32'h5EED_2024));
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;
      // R12: reset state
      chk("R12 tx_level", 32'(tx_level), 0);
      chk("R12 rx_level", 32'(rx_level), 0);
      chk("R12 rx_empty", 32'(rx_empty), 1);
      chk("R12 tx_full", 32'(tx_full), 0);
      chk("R12 errors", 32'({tx_ovf_err, rx_udf_err}), 0);
      chk("R12 rdata", dat_rdata, 0);
      chk("R12 pend_dma", 32'({rst_pend, tx_dma_req, rx_dma_req}), 0);
      // R8: depth codes
      chk("R8 tx_depth_code", 32'(tx_depth_code), TX_AW - 1);
      chk("R8 rx_depth_code", 32'(rx_depth_code), RX_AW - 1);

      // R1: byte writes until full, then one dropped write (R6)
      merge_en = 0; unit_len = 7; tx_dma_en = 1;
      for (int i = 0; i <= TXD; i++) begin
         dat_wr = 1; dat_wdata = 32'hAB00_0010 + 32'(i); step();
      end
      idle(); step();
      chk("R6 tx_full_after_fill", 32'(tx_ovf_err), 1);
      // drain a few in order (R1)
      ser_tx_take = 1; repeat (3) step(); idle();
      // R7: transmit flush
      ctl_wr = 1; ctl_wdata = 3'b100; step(); idle(); step();
      chk("R7 tx_flushed", 32'(tx_level), 0);
      // R2: packed write, low byte first
      merge_en = 1; dat_wr = 1; dat_wdata = 32'h4433_2211; step(); idle();
      chk("R2 first_byte", 32'(ser_tx_byte), 32'h11);
      // R4: unit length not 8 bits means single byte
      unit_len = 5'd3; dat_wr = 1; dat_wdata = 32'h99887766; step(); idle();
      chk("R4 single_byte", 32'(tx_level), 5);
      unit_len = 5'd7;
      // R11: overfill receive side
      ser_rx_put = 1; rx_dma_en = 1;
      for (int i = 0; i < RXD + 3; i++) begin ser_rx_byte = 8'(8'h30 + i); step(); end
      idle();
      chk("R11 rx_capped", 32'(rx_level), RXD);
      // R3: packed read then byte read
      dat_rd = 1; step(); idle();
      chk("R3 packed_read", dat_rdata, 32'h3332_3130);
      merge_en = 0; dat_rd = 1; step(); idle();
      chk("R3 byte_read", dat_rdata, 32'h34);
      // R6: read underflow
      ctl_wr = 1; ctl_wdata = 3'b010; step(); idle(); step();
      dat_rd = 1; step(); idle();
      chk("R6 underflow", 32'(rx_udf_err), 1);
      // R7: whole-port flush clears errors
      ctl_wr = 1; ctl_wdata = 3'b001; step(); idle(); step();
      chk("R7 all_clear", 32'({tx_ovf_err, rx_udf_err, rst_pend}), 0);

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         merge_en    = $urandom_range(0, 1);
         unit_len    = ($urandom_range(0, 7) == 0) ? 5'd3 : 5'd7;
         dat_wr      = ($urandom_range(0, 2) == 0);
         dat_wdata   = $urandom;
         dat_rd      = ($urandom_range(0, 2) == 0);
         ser_tx_take = ($urandom_range(0, 1) == 0);
         ser_rx_put  = ($urandom_range(0, 1) == 0);
         ser_rx_byte = 8'($urandom);
         ctl_wr      = ($urandom_range(0, 79) == 0);
         ctl_wdata   = 3'($urandom);
         tx_dma_en   = ($urandom_range(0, 3) != 0);
         rx_dma_en   = ($urandom_range(0, 3) != 0);
         step();
      end
      idle(); step();
      report();
   end
endmodule